// File: doc/BRIEF.md
# Manchester Packet Receiver and Validator

This block takes a raw, oversampled radio data line and turns it into a checked packet. While idle it hunts for a run of alternating preamble bits followed by an exact 16-bit start character. Once the start character is found, it clocks in a packet whose byte count was fixed before reception began. It decodes each bit from a pair of opposite half-bits, least significant bit first, and aborts at the first malformed pair.

Every four bytes the transmitter inserts a short low-then-high marker. The receiver re-times its half-bit sampling on the rising edge of that marker instead of recovering a clock. A 16-bit mod-255 Fletcher check covers the start character and every packet byte. The five leading bytes form the destination address: a product type followed by four serial bytes. The packet is accepted when it carries this node's own address or the all-ones broadcast address.

Each received byte appears on a write port together with its position. The packet type byte is held on its own output. A finished packet ends with exactly one single-cycle pulse, either valid or error, and the receiver then goes back to hunting.

Top module: `rxm_packet_rx`

## Requirements
- R1: Reception starts only after at least 11 alternating preamble bits (the last one a 1) immediately followed by the start character `SYNC_WORD`, sent low byte first and LSB first. With fewer preamble bits, no packet is received and neither flag pulses.
- R2: Data bits are taken LSB first. Each completed byte is presented for one cycle on `wr_en_o`/`wr_data_o`, with `wr_idx_o` = 0 for the first byte after the start character, counting upward.
- R3: Each bit is a pair of half-bits (b, not b), each half lasting `HALF_CYC` clocks. A pair whose two halves are equal ends reception with an error pulse.
- R4: `exp_len_i` (at least 8) is captured when the start character matches, and it counts every byte after the start character, including the two check bytes. If the line stops before that many bytes arrive, the result is an error pulse.
- R5: After every fourth byte, when more bytes follow, the line carries a low half-bit and then a high half-bit. Sampling is re-timed on that rising edge. If no rising edge arrives within three half-bit periods, the result is an error pulse.
- R6: The check is a Fletcher sum mod 255 over both start character bytes and all `exp_len_i` bytes. It passes only when both running sums are zero after the last byte, so a single flipped data bit causes an error pulse.
- R7: Byte 0 is compared with `node_type_i`, and bytes 1 to 4 with `node_serial_i`, least significant byte first. If all five bytes are 0xFF, the packet is a broadcast. Any other mix, including type 0xFF with the node's own serial, is a mismatch. Byte 5 is shown on `ptype_o`.
- R8: `pkt_valid_o` pulses for one cycle only when the check passes and the address matches or is a broadcast. `own_hit_o` and `bcast_hit_o` then show which case applied. In every other case, `pkt_err_o` pulses instead. The two flags never pulse together.
- R9: While `rst` is high, all flags and write strobes are 0, and a packet in progress is dropped without any pulse.
- R10: After an error or a reset, the receiver returns to the hunt and accepts the next well-formed packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw received data line |
| exp_len_i | input | LEN_W | Byte count after the start character, including check bytes |
| node_type_i | input | 8 | This node's product type byte |
| node_serial_i | input | 32 | This node's serial number |
| wr_en_o | output | 1 | Byte write strobe |
| wr_idx_o | output | LEN_W | Position of the written byte |
| wr_data_o | output | 8 | Written byte |
| ptype_o | output | 8 | Packet type byte of the latest packet |
| pkt_valid_o | output | 1 | Single-cycle pulse for an accepted packet |
| pkt_err_o | output | 1 | Single-cycle pulse for a rejected or aborted packet |
| own_hit_o | output | 1 | Last accepted packet carried this node's address |
| bcast_hit_o | output | 1 | Last accepted packet was a broadcast |

## Verification
The properties assume the following about the inputs:
- `exp_len_i` is at least 8 and does not change while a packet is arriving.
- The line changes no faster than one half-bit period.
- `HALF_CYC` is at least 4.
- The node's own address is not all ones.

The stimulus respects all four. Every packet length is 8 or more. Half-bits are driven for exactly `HALF_CYC` clocks. The node address is fixed at a value that is not a broadcast. Faults are introduced only as whole half-bits (a repeated half, a missing marker, an early stop), so the receiver is always tested on its own rules and never on glitches narrower than a half-bit.

// File: rtl/rxm_pkg.sv
package rxm_pkg;

    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_DATA = 2'd1,
        RX_SYNC = 2'd2
    } rx_state_e;

    localparam int ADDR_BYTES = 5;
    localparam int TYPE_POS   = 5;
    localparam int MIN_LEN    = 8;

    typedef struct packed {
        logic own;
        logic bcast;
    } hit_t;

    // Sum of two residues mod 255, result kept in 0..254.
    function automatic logic [7:0] mod255_add(input logic [7:0] a, input logic [7:0] b);
        logic [8:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 9'd255) s = s - 9'd255;
        return s[7:0];
    endfunction

endpackage

// File: rtl/rxm_halfbit_sampler.sv
module rxm_halfbit_sampler #(
    parameter int HALF_CYC = 1500
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    input  logic track_any_i,
    input  logic arm_rise_i,
    output logic strobe_o,
    output logic bit_o,
    output logic rise_o
);
    localparam int CNT_W = $clog2(HALF_CYC + HALF_CYC / 2 + 1);
    localparam logic [CNT_W-1:0] LD_MID  = CNT_W'(HALF_CYC / 2 - 1);
    localparam logic [CNT_W-1:0] LD_FULL = CNT_W'(HALF_CYC - 1);
    localparam logic [CNT_W-1:0] LD_MARK = CNT_W'(HALF_CYC + HALF_CYC / 2 - 1);

    logic             meta_q, sync_q, prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic             any_edge, re_any, re_mark;

    assign any_edge = sync_q ^ prev_q;
    assign rise_o   = sync_q & ~prev_q;
    assign re_any   = track_any_i & any_edge;
    assign re_mark  = arm_rise_i & rise_o;
    assign strobe_o = (cnt_q == '0) && !re_any && !re_mark;
    assign bit_o    = sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
            cnt_q  <= LD_FULL;
        end else begin
            meta_q <= line_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
            if (re_any)             cnt_q <= LD_MID;
            else if (re_mark)       cnt_q <= LD_MARK;
            else if (cnt_q == '0)   cnt_q <= LD_FULL;
            else                    cnt_q <= cnt_q - 1'b1;
        end
    end

    p_strobe_gap_r3: assert property (@(posedge clk) disable iff (rst)
        strobe_o |=> !strobe_o);

endmodule

// File: rtl/rxm_fletcher.sv
module rxm_fletcher
    import rxm_pkg::*;
#(
    parameter logic [7:0] INIT_S1 = 8'd0,
    parameter logic [7:0] INIT_S2 = 8'd0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       init_i,
    input  logic       upd_i,
    input  logic [7:0] byte_i,
    output logic       zero_next_o
);
    logic [7:0] s1_q, s2_q, n1, n2;

    assign n1 = mod255_add(s1_q, byte_i);
    assign n2 = mod255_add(s2_q, n1);
    assign zero_next_o = (n1 == 8'd0) && (n2 == 8'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 8'd0;
            s2_q <= 8'd0;
        end else if (init_i) begin
            s1_q <= INIT_S1;
            s2_q <= INIT_S2;
        end else if (upd_i) begin
            s1_q <= n1;
            s2_q <= n2;
        end
    end

    p_sum_range_r6: assert property (@(posedge clk) disable iff (rst)
        (s1_q < 8'd255) && (s2_q < 8'd255));

endmodule

// File: rtl/rxm_addr_match.sv
module rxm_addr_match
    import rxm_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             upd_i,
    input  logic [LEN_W-1:0] idx_i,
    input  logic [7:0]       byte_i,
    input  logic [7:0]       node_type_i,
    input  logic [31:0]      node_serial_i,
    output hit_t             hit_o
);
    logic [7:0] exp_b;
    logic       in_addr;

    always_comb begin
        exp_b = node_type_i;
        for (int k = 1; k < ADDR_BYTES; k++) begin
            if (int'(idx_i) == k) exp_b = node_serial_i[8*(k-1) +: 8];
        end
    end

    assign in_addr = int'(idx_i) < ADDR_BYTES;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o <= '0;
        end else if (start_i) begin
            hit_o <= '{own: 1'b1, bcast: 1'b1};
        end else if (upd_i && in_addr) begin
            hit_o.own   <= hit_o.own   & (byte_i == exp_b);
            hit_o.bcast <= hit_o.bcast & (byte_i == 8'hFF);
        end
    end

    p_bcast_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (!hit_o.bcast && !start_i) |=> !hit_o.bcast);

endmodule

// File: rtl/rxm_packet_rx.sv
module rxm_packet_rx
    import rxm_pkg::*;
#(
    parameter int          HALF_CYC    = 1500,
    parameter int          PRE_BITS    = 11,
    parameter logic [15:0] SYNC_WORD   = 16'h6572,
    parameter int          LEN_W       = 8,
    parameter int          GROUP_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    input  logic [LEN_W-1:0] exp_len_i,
    input  logic [7:0]       node_type_i,
    input  logic [31:0]      node_serial_i,
    output logic             wr_en_o,
    output logic [LEN_W-1:0] wr_idx_o,
    output logic [7:0]       wr_data_o,
    output logic [7:0]       ptype_o,
    output logic             pkt_valid_o,
    output logic             pkt_err_o,
    output logic             own_hit_o,
    output logic             bcast_hit_o
);
    localparam int HUNT_W = 2 * (PRE_BITS + 16);
    localparam int GB_LOG = $clog2(GROUP_BYTES);
    localparam logic [7:0] FL_S1 = mod255_add(SYNC_WORD[7:0], SYNC_WORD[15:8]);
    localparam logic [7:0] FL_S2 = mod255_add(SYNC_WORD[7:0], FL_S1);

    // Half-bit pattern of trailing preamble plus start character, newest at bit 0.
    function automatic logic [HUNT_W-1:0] build_pattern();
        logic [HUNT_W-1:0] p;
        int h;
        logic b;
        p = '0;
        h = 0;
        for (int k = 0; k < PRE_BITS + 16; k++) begin
            if (k < PRE_BITS) b = ((PRE_BITS - 1 - k) % 2) == 0;
            else              b = SYNC_WORD[k - PRE_BITS];
            p[HUNT_W-1-h] = b;
            p[HUNT_W-2-h] = ~b;
            h += 2;
        end
        return p;
    endfunction

    localparam logic [HUNT_W-1:0] HUNT_PAT = build_pattern();

    rx_state_e         state;
    logic [HUNT_W-1:0] hunt_sr;
    logic              first_half, half_sel;
    logic [2:0]        bit_cnt;
    logic [7:0]        byte_sr;
    logic [LEN_W-1:0]  byte_idx, len_q;
    logic [1:0]        mark_wait;

    logic              s_strobe, s_bit, s_rise;
    logic [HUNT_W-1:0] hunt_next;
    logic              hunt_hit, pair_done, pair_bad, byte_done, last_byte, group_end;
    logic [7:0]        byte_val;
    logic              fl_zero;
    hit_t              hit;

    rxm_halfbit_sampler #(.HALF_CYC(HALF_CYC)) u_samp (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line_i),
        .track_any_i (state == RX_HUNT),
        .arm_rise_i  (state == RX_SYNC),
        .strobe_o    (s_strobe),
        .bit_o       (s_bit),
        .rise_o      (s_rise)
    );

    assign hunt_next = {hunt_sr[HUNT_W-2:0], s_bit};
    assign hunt_hit  = (state == RX_HUNT) && s_strobe && (hunt_next == HUNT_PAT);
    assign pair_done = (state == RX_DATA) && s_strobe && half_sel;
    assign pair_bad  = pair_done && (first_half == s_bit);
    assign byte_done = pair_done && !pair_bad && (bit_cnt == 3'd7);
    assign byte_val  = {first_half, byte_sr[7:1]};
    assign last_byte = byte_idx == (len_q - 1'b1);
    assign group_end = &byte_idx[GB_LOG-1:0];

    rxm_fletcher #(.INIT_S1(FL_S1), .INIT_S2(FL_S2)) u_fl (
        .clk         (clk),
        .rst         (rst),
        .init_i      (hunt_hit),
        .upd_i       (byte_done),
        .byte_i      (byte_val),
        .zero_next_o (fl_zero)
    );

    rxm_addr_match #(.LEN_W(LEN_W)) u_addr (
        .clk           (clk),
        .rst           (rst),
        .start_i       (hunt_hit),
        .upd_i         (byte_done),
        .idx_i         (byte_idx),
        .byte_i        (byte_val),
        .node_type_i   (node_type_i),
        .node_serial_i (node_serial_i),
        .hit_o         (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= RX_HUNT;
            hunt_sr     <= '0;
            first_half  <= 1'b0;
            half_sel    <= 1'b0;
            bit_cnt     <= 3'd0;
            byte_sr     <= 8'd0;
            byte_idx    <= '0;
            len_q       <= '0;
            mark_wait   <= 2'd0;
            wr_en_o     <= 1'b0;
            wr_idx_o    <= '0;
            wr_data_o   <= 8'd0;
            ptype_o     <= 8'd0;
            pkt_valid_o <= 1'b0;
            pkt_err_o   <= 1'b0;
            own_hit_o   <= 1'b0;
            bcast_hit_o <= 1'b0;
        end else begin
            wr_en_o     <= 1'b0;
            pkt_valid_o <= 1'b0;
            pkt_err_o   <= 1'b0;
            case (state)
                RX_HUNT: begin
                    if (s_strobe) begin
                        hunt_sr <= hunt_next;
                        if (hunt_hit) begin
                            state    <= RX_DATA;
                            len_q    <= exp_len_i;
                            byte_idx <= '0;
                            bit_cnt  <= 3'd0;
                            half_sel <= 1'b0;
                        end
                    end
                end
                RX_DATA: begin
                    if (s_strobe && !half_sel) begin
                        first_half <= s_bit;
                        half_sel   <= 1'b1;
                    end else if (pair_done) begin
                        half_sel <= 1'b0;
                        if (pair_bad) begin
                            pkt_err_o <= 1'b1;
                            state     <= RX_HUNT;
                            hunt_sr   <= '0;
                        end else begin
                            byte_sr <= byte_val;
                            bit_cnt <= bit_cnt + 3'd1;
                            if (byte_done) begin
                                wr_en_o   <= 1'b1;
                                wr_idx_o  <= byte_idx;
                                wr_data_o <= byte_val;
                                if (int'(byte_idx) == TYPE_POS) ptype_o <= byte_val;
                                if (last_byte) begin
                                    state   <= RX_HUNT;
                                    hunt_sr <= '0;
                                    if (fl_zero && (hit.own || hit.bcast)) begin
                                        pkt_valid_o <= 1'b1;
                                        own_hit_o   <= hit.own;
                                        bcast_hit_o <= hit.bcast;
                                    end else begin
                                        pkt_err_o   <= 1'b1;
                                        own_hit_o   <= 1'b0;
                                        bcast_hit_o <= 1'b0;
                                    end
                                end else begin
                                    byte_idx <= byte_idx + 1'b1;
                                    if (group_end) begin
                                        state     <= RX_SYNC;
                                        mark_wait <= 2'd0;
                                    end
                                end
                            end
                        end
                    end
                end
                RX_SYNC: begin
                    if (s_rise) begin
                        state    <= RX_DATA;
                        half_sel <= 1'b0;
                    end else if (s_strobe) begin
                        mark_wait <= mark_wait + 2'd1;
                        if (mark_wait == 2'd2) begin
                            pkt_err_o <= 1'b1;
                            state     <= RX_HUNT;
                            hunt_sr   <= '0;
                        end
                    end
                end
                default: state <= RX_HUNT;
            endcase
        end
    end

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(pkt_valid_o && pkt_err_o));

    p_valid_single_r8: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_o |=> !pkt_valid_o);

    p_valid_after_data_r4: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_o |-> ($past(state) == RX_DATA));

    p_len_floor_r4: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DATA) |-> (int'(len_q) >= MIN_LEN));

    p_mark_edge_r5: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DATA && $past(state) == RX_SYNC) |-> $past(s_rise));

    p_wr_range_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_idx_o < len_q));

    p_abort_pair_r3: assert property (@(posedge clk) disable iff (rst)
        pair_bad |=> (pkt_err_o && state == RX_HUNT));

endmodule

// File: tb/rxm_packet_rx_test.sv
module rxm_packet_rx_test;
    localparam int          HALF  = 8;
    localparam logic [15:0] SW    = 16'h6572;
    localparam logic [7:0]  NTYPE = 8'h3C;
    localparam logic [31:0] NSER  = 32'hA1B2C3D4;

    // {expect[3:0], addr mode[3:0], fault[3:0], data length[7:0]}
    // expect: 0 none, 1 valid own, 2 valid broadcast, 3 error
    // addr: 0 own, 1 all 0xFF, 2 serial byte altered, 3 type 0xFF + own serial
    // fault: 0 none, 1 flipped data bit, 2 equal half pair, 3 short preamble,
    //        4 line stops at first marker, 5 expected length one too long
    localparam logic [19:0] VEC [12] = '{
        20'h1_0_0_06, 20'h2_1_0_06, 20'h3_2_0_06, 20'h1_0_0_1A,
        20'h3_0_1_06, 20'h3_0_2_0A, 20'h0_0_3_06, 20'h3_0_4_0A,
        20'h3_0_5_06, 20'h1_0_0_02, 20'h3_3_0_06, 20'h1_0_0_00
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line = 1'b0;
    logic [7:0] exp_len = 8'd8;
    logic       wr_en, pkt_valid, pkt_err, own_hit, bcast_hit;
    logic [7:0] wr_idx, wr_data, ptype;

    int n_chk = 0;
    int n_bad = 0;
    int vcnt  = 0;
    int ecnt  = 0;
    logic [7:0] frm [0:63];
    logic [7:0] cap [0:63];

    always #4 clk = ~clk;

    rxm_packet_rx #(.HALF_CYC(HALF), .SYNC_WORD(SW)) uut (
        .clk(clk), .rst(rst), .line_i(line), .exp_len_i(exp_len),
        .node_type_i(NTYPE), .node_serial_i(NSER),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
        .ptype_o(ptype), .pkt_valid_o(pkt_valid), .pkt_err_o(pkt_err),
        .own_hit_o(own_hit), .bcast_hit_o(bcast_hit)
    );

    always @(posedge clk) begin
        if (pkt_valid) vcnt <= vcnt + 1;
        if (pkt_err)   ecnt <= ecnt + 1;
        if (wr_en)     cap[wr_idx[5:0]] <= wr_data;
    end

    task automatic check(input logic ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic send_half(input logic b);
        line = b;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        send_half(b);
        send_half(~b);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) send_half(1'b0);
    endtask

    task automatic build(input int am, input int dl, input bit badsum, input int tag);
        int n, s1, s2, a;
        n = 8 + dl;
        for (int k = 0; k < 4; k++) frm[1+k] = NSER[8*k +: 8];
        frm[0] = NTYPE;
        if (am == 1) for (int k = 0; k < 5; k++) frm[k] = 8'hFF;
        if (am == 2) frm[2] = frm[2] ^ 8'h01;
        if (am == 3) frm[0] = 8'hFF;
        frm[5] = 8'(8'hC0 + tag);
        for (int k = 0; k < dl; k++) frm[6+k] = 8'((k * 37 + 11 + tag * 5) & 255);
        s1 = (int'(SW[7:0])) % 255;
        s2 = s1;
        s1 = (s1 + int'(SW[15:8])) % 255;
        s2 = (s2 + s1) % 255;
        for (int k = 0; k < n - 2; k++) begin
            s1 = (s1 + int'(frm[k])) % 255;
            s2 = (s2 + s1) % 255;
        end
        a = (s1 + s2) % 255;
        frm[n-2] = 8'(255 - a);
        a = (s1 + int'(frm[n-2])) % 255;
        frm[n-1] = 8'(255 - a);
        if (badsum) frm[6] = frm[6] ^ 8'h01;
    endtask

    task automatic send_frame(input int pre_bits, input int nb, input int viol_byte, input bit stop_mark);
        idle(6);
        for (int k = 0; k < pre_bits; k++) send_bit(((pre_bits - 1 - k) % 2) == 0);
        for (int k = 0; k < 16; k++) send_bit(SW[k]);
        for (int i = 0; i < nb; i++) begin
            for (int j = 0; j < 8; j++) begin
                if (i == viol_byte && j == 3) begin
                    send_half(frm[i][j]);
                    send_half(frm[i][j]);
                end else begin
                    send_bit(frm[i][j]);
                end
            end
            if ((i % 4) == 3 && i != nb - 1) begin
                if (stop_mark) begin
                    idle(10);
                    return;
                end
                send_half(1'b0);
                send_half(1'b1);
            end
        end
        idle(10);
    endtask

    task automatic run_vec(input int i);
        logic [19:0] v;
        int ex, am, cr, dl, v0, e0, nb, bad;
        string tag;
        v  = VEC[i];
        ex = int'(v[19:16]);
        am = int'(v[15:12]);
        cr = int'(v[11:8]);
        dl = int'(v[7:0]);
        nb = 8 + dl;
        case (cr)
            1: tag = "R6";
            2: tag = "R3";
            3: tag = "R1";
            4: tag = "R5";
            5: tag = "R4";
            default: tag = (am >= 2) ? "R7" : "R8";
        endcase
        build(am, dl, cr == 1, i);
        exp_len = 8'(nb + ((cr == 5) ? 1 : 0));
        v0 = vcnt;
        e0 = ecnt;
        send_frame((cr == 3) ? 10 : 16, nb, (cr == 2) ? 7 : -1, cr == 4);
        repeat (20) @(negedge clk);
        check(vcnt - v0 == ((ex == 1 || ex == 2) ? 1 : 0), tag, vcnt - v0, (ex == 1 || ex == 2) ? 1 : 0);
        check(ecnt - e0 == ((ex == 3) ? 1 : 0), tag, ecnt - e0, (ex == 3) ? 1 : 0);
        if (ex == 1 || ex == 2) begin
            check(own_hit == (ex == 1), "R7 own", int'(own_hit), (ex == 1) ? 1 : 0);
            check(bcast_hit == (ex == 2), "R7 bcast", int'(bcast_hit), (ex == 2) ? 1 : 0);
            check(ptype == frm[5], "R7 type", int'(ptype), int'(frm[5]));
            bad = -1;
            for (int k = nb - 1; k >= 0; k--) if (cap[k] !== frm[k]) bad = k;
            check(bad < 0, "R2 bytes", (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(frm[bad]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check(!pkt_valid && !pkt_err && !wr_en && !own_hit && !bcast_hit, "R9 reset",
              int'({pkt_valid, pkt_err, wr_en, own_hit, bcast_hit}), 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        for (int i = 0; i < 12; i++) run_vec(i);

        // R9: reset in the middle of a frame drops it without a pulse.
        begin
            int v0, e0;
            build(0, 10, 1'b0, 20);
            exp_len = 8'd18;
            v0 = vcnt;
            e0 = ecnt;
            fork
                send_frame(16, 18, -1, 1'b0);
                begin
                    repeat (900) @(negedge clk);
                    rst = 1'b1;
                    repeat (3) @(negedge clk);
                    rst = 1'b0;
                end
            join
            repeat (20) @(negedge clk);
            check((vcnt - v0) + (ecnt - e0) == 0, "R9 mid-frame", (vcnt - v0) + (ecnt - e0), 0);
            check(!own_hit && !bcast_hit, "R9 flags", int'({own_hit, bcast_hit}), 0);
        end

        // R10: next well-formed frame after reset is accepted.
        begin
            int v0;
            build(1, 4, 1'b0, 21);
            exp_len = 8'd12;
            v0 = vcnt;
            send_frame(11, 12, -1, 1'b0);
            repeat (20) @(negedge clk);
            check(vcnt - v0 == 1, "R10 recover", vcnt - v0, 1);
            check(bcast_hit == 1'b1, "R10 bcast", int'(bcast_hit), 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule